// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

The engine receives a stream of 32-bit command words. The top byte of each word selects an operation and the low bits carry its argument. Five words set the working parameters: destination start, source start, rectangle width, rectangle height and a 16-bit fill colour. These values stay in the engine until they are overwritten. A start word then runs one of two operations over a frame buffer with 16 bits per pixel. A solid fill writes the colour into every pixel of the rectangle. A copy moves a rectangle from the source region to the destination region.

Memory is reached through a single port addressed in 16-bit halfwords. Read data returns in the cycle after the read. The line pitch, in pixels, is a static input. While an operation runs, `busy` stays high and the command input is stalled. When the operation ends, an optional one-cycle `done` pulse is raised.

Top module: `rect_blitter`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are 0 and `cmd_ready` is 1.
- R2: The opcode is bits 31:24 of the command word, and each parameter word stores only its own field. 0x0B stores bits 15:0 as the fill colour. 0x0C stores the destination and 0x0D the source; each is a byte address, of which bits 23:1 are kept as the halfword address and bit 0 is dropped. 0x0E stores bits 9:0 as width minus one. 0x0F stores bits 9:0 as height minus one.
- R3: A word with any other opcode changes no parameter and starts nothing.
- R4: Opcode 0x23 starts a fill. The fill colour is written to halfword address D + y*P + x for every x from 0 to W and every y from 0 to H, one write per cycle. D is the destination halfword address, P is `pitch`, and W and H are the stored counts. No other address is written.
- R5: Opcode 0x21 starts a copy. For each pixel, the engine reads halfword S + y*P + x and writes the returned data to D + y*P + x in the next cycle. S is the source halfword address. Reads and writes never share a cycle.
- R6: Pixels are visited in order: x rises within a row, and rows go from top to bottom.
- R7: `busy` rises in the cycle after a start word is accepted. It stays high for exactly (W+1)*(H+1) cycles for a fill and for twice that number for a copy.
- R8: While `busy` is high, `cmd_ready` is 0 and no word is consumed. A word held on the input is taken only once the engine is idle.
- R9: Bit 1 of a start word requests completion notice. If it is set, `done` is high for exactly one cycle, the cycle after the last write, and `busy` is already low in that cycle. If it is clear, `done` stays low.
- R10: Parameters keep their values across operations, so a later start word reuses them without reloading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Engine can take a word |
| cmd_data | input | 32 | Command word |
| pitch | input | PITCH_W | Line pitch in pixels |
| mem_addr | output | AW-1 | Halfword address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |

## Verification
A wrong column or row counter appears at once as a write address that breaks the expected sequence. The bench tracks this sequence on every strobe, so a fault is reported on the first wrong access. A row base that fails to step by the pitch shows up as soon as the second row starts. A stale parameter register or a held word consumed too early appears only after the operation, in the final memory image or in the next operation's colour. For that reason, every run ends with a full comparison of memory against an image the bench builds arithmetically. Busy length and done-pulse counts expose a faulty state machine within one operation.

// File: rtl/rect_blitter.sv
module rect_blitter #(
  parameter int AW      = 24,
  parameter int CW      = 10,
  parameter int PITCH_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [31:0]        cmd_data,
  input  logic [PITCH_W-1:0] pitch,
  output logic [AW-2:0]      mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [15:0]        mem_wdata,
  input  logic [15:0]        mem_rdata,
  output logic               busy,
  output logic               done
);
  localparam int HW = AW - 1;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_RD, S_WR} st_t;
  st_t st;

  logic [15:0]   colour;
  logic [HW-1:0] dst_base, src_base, dst_row, src_row;
  logic [CW-1:0] wmax, hmax, x, y;
  logic          irq_req;

  wire        take    = cmd_valid && cmd_ready;
  wire [7:0]  op      = cmd_data[31:24];
  wire        wr_step = (st == S_FILL) || (st == S_WR);
  wire        row_end = (x == wmax);
  wire        last    = row_end && (y == hmax);

  assign busy      = (st != S_IDLE);
  assign cmd_ready = !busy;
  assign mem_rd    = (st == S_RD);
  assign mem_wr    = wr_step;
  assign mem_addr  = ((st == S_RD) ? src_row : dst_row) + HW'(x);
  assign mem_wdata = (st == S_FILL) ? colour : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      colour   <= '0;
      dst_base <= '0;
      src_base <= '0;
      wmax     <= '0;
      hmax     <= '0;
      x        <= '0;
      y        <= '0;
      dst_row  <= '0;
      src_row  <= '0;
      irq_req  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        case (op)
          8'h0B: colour   <= cmd_data[15:0];
          8'h0C: dst_base <= cmd_data[AW-1:1];
          8'h0D: src_base <= cmd_data[AW-1:1];
          8'h0E: wmax     <= cmd_data[CW-1:0];
          8'h0F: hmax     <= cmd_data[CW-1:0];
          8'h21, 8'h23: begin
            x       <= '0;
            y       <= '0;
            dst_row <= dst_base;
            src_row <= src_base;
            irq_req <= cmd_data[1];
            st      <= (op == 8'h23) ? S_FILL : S_RD;
          end
          default: ;
        endcase
      end
      if (st == S_RD) st <= S_WR;
      if (wr_step) begin
        if (last) begin
          st   <= S_IDLE;
          done <= irq_req;
        end else begin
          if (st == S_WR) st <= S_RD;
          if (row_end) begin
            x       <= '0;
            y       <= y + 1'b1;
            dst_row <= dst_row + HW'(pitch);
            src_row <= src_row + HW'(pitch);
          end else begin
            x <= x + 1'b1;
          end
        end
      end
    end
  end

  assert_reset_R1: assert property (@(posedge clk) $past(!rst_n) |-> !busy && !done)
    else $error("R1 state after reset");
  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr))
    else $error("R5 read and write together");
  assert_rd_then_wr_R5: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> mem_wr)
    else $error("R5 read not followed by write");
  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid && cmd_ready))
    else $error("R7 busy without accepted word");
  assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(mem_wr))
    else $error("R9 done not after last write");
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done)
    else $error("R9 done longer than one cycle");
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !$past(busy) |-> !cmd_ready)
    else $error("R8 ready while busy");
endmodule

// File: tb/tb_rect_blitter.sv
module tb_rect_blitter;
  localparam int CLK_PERIOD = 10;
  localparam int MEMN = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_data = '0;
  logic [11:0] pitch = 12'd16;
  logic [22:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        busy, done;

  rect_blitter dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .pitch(pitch), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] pat(int i);
    return 16'(i * 37 + 5) ^ 16'h5A00;
  endfunction

  logic [15:0] mem [0:MEMN-1];
  logic [15:0] expm [0:MEMN-1];
  logic        pre_req = 1'b0;

  always @(posedge clk) begin
    if (pre_req) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= pat(i);
    end else begin
      if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  int checks = 0, errors = 0;
  int cur_w, cur_h, cur_dst, cur_src, cur_p;
  logic [15:0] cur_col;
  int wr_idx, rd_idx, seq_err, busy_cyc, done_cnt, rdy_err;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cyc++;
      if (done) done_cnt++;
      if (busy && cmd_ready) rdy_err++;
      if (mem_wr) begin
        if (int'(mem_addr) != cur_dst + (wr_idx / (cur_w + 1)) * cur_p + wr_idx % (cur_w + 1)) seq_err++;
        wr_idx++;
      end
      if (mem_rd) begin
        if (int'(mem_addr) != cur_src + (rd_idx / (cur_w + 1)) * cur_p + rd_idx % (cur_w + 1)) seq_err++;
        rd_idx++;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic prefill();
    @(negedge clk);
    pre_req = 1'b1;
    @(negedge clk);
    pre_req = 1'b0;
    for (int i = 0; i < MEMN; i++) expm[i] = pat(i);
  endtask

  task automatic setup(int dst_b, int src_b, int w, int h, logic [15:0] col);
    send({8'h0C, 24'(dst_b)});
    send({8'h0D, 24'(src_b)});
    send({8'h0E, 24'(w)});
    send({8'h0F, 24'(h)});
    send({8'h0B, 8'h00, col});
    cur_dst = (dst_b & 24'hFFFFFE) / 2;
    cur_src = (src_b & 24'hFFFFFE) / 2;
    cur_w = w & 10'h3FF;
    cur_h = h & 10'h3FF;
    cur_col = col;
  endtask

  task automatic start(bit copy, bit intr);
    cur_p = int'(pitch);
    wr_idx = 0; rd_idx = 0; seq_err = 0; busy_cyc = 0; done_cnt = 0; rdy_err = 0;
    if (!copy) rd_idx = 0;
    for (int yy = 0; yy <= cur_h; yy++)
      for (int xx = 0; xx <= cur_w; xx++)
        expm[cur_dst + yy * cur_p + xx] = copy ? expm[cur_src + yy * cur_p + xx] : cur_col;
    send({copy ? 8'h21 : 8'h23, 22'd0, intr, 1'b1});
  endtask

  task automatic finish_op(string tag, bit copy, bit intr);
    int n, bad;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    n = (cur_w + 1) * (cur_h + 1);
    chk(seq_err == 0, {"R6 ", tag, " address order"}, seq_err, 0);
    chk(wr_idx == n, {"R4 ", tag, " write count"}, wr_idx, n);
    chk(rd_idx == (copy ? n : 0), {"R5 ", tag, " read count"}, rd_idx, copy ? n : 0);
    chk(busy_cyc == (copy ? 2 * n : n), {"R7 ", tag, " busy cycles"}, busy_cyc, copy ? 2 * n : n);
    chk(done_cnt == int'(intr), {"R9 ", tag, " done pulses"}, done_cnt, int'(intr));
    chk(rdy_err == 0, {"R8 ", tag, " ready while busy"}, rdy_err, 0);
    bad = 0;
    for (int i = 0; i < MEMN; i++) if (mem[i] !== expm[i]) bad++;
    chk(bad == 0, {copy ? "R5 " : "R4 ", tag, " memory image"}, bad, 0);
  endtask

  initial begin
    int tmo = 0;
    fork
      begin
        repeat (150000) @(posedge clk);
        tmo = 1;
      end
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && cmd_ready && !mem_rd && !mem_wr, "R1 reset state",
            {busy, done, cmd_ready, mem_rd, mem_wr}, 5'b00100);
        rst_n = 1'b1;

        for (int w = 0; w < 4; w++)
          for (int h = 0; h < 4; h++) begin
            prefill();
            setup(2 * (64 + (w * 4 + h) * 40), 0, w, h, 16'(16'hC000 + w * 16 + h));
            start(1'b0, 1'((w + h) % 2));
            finish_op("fill sweep", 1'b0, 1'((w + h) % 2));
          end

        for (int w = 0; w < 4; w++)
          for (int h = 0; h < 4; h++) begin
            prefill();
            setup(2 * (2400 + w * 80 + h * 7), 2 * (900 + w * 9 + h * 3), w, h, 16'h0);
            start(1'b1, 1'((w + h + 1) % 2));
            finish_op("copy sweep", 1'b1, 1'((w + h + 1) % 2));
          end

        pitch = 12'd23;
        prefill();
        setup(2 * 1500 + 1, 0, 32'h0000_FC01, 32'h0000_0402, 16'h1357);
        chk(cur_dst == 1500 && cur_w == 1 && cur_h == 2, "R2 field masks", cur_dst, 1500);
        send(32'h0A00_FFFF);
        send(32'h3000_0000);
        send(32'h1000_0005);
        start(1'b0, 1'b1);
        finish_op("R2 R3 masked and ignored words", 1'b0, 1'b1);

        prefill();
        setup(2 * 300, 2 * 100, 5, 1, 16'hAAAA);
        start(1'b0, 1'b1);
        send(32'h0B00_5555);
        cur_col = 16'h5555;
        finish_op("R8 held word during fill", 1'b0, 1'b1);
        start(1'b0, 1'b0);
        finish_op("R10 reuse after held word", 1'b0, 1'b0);
        start(1'b1, 1'b1);
        finish_op("R10 copy with kept source", 1'b1, 1'b1);
      end
    join_any
    if (tmo) chk(1'b0, "watchdog expired", tmo, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule